// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Port

This block controls one general-purpose I/O port. It has up to eight pins and a byte-wide register interface of the kind a small microcontroller core uses. Software writes an output latch and two mode registers. Bit n of the first mode register and bit n of the second together form a two-bit code for pin n. That code sets how the pin is driven: quasi-bidirectional with a weak pull-up, push-pull, input-only, or open-drain. Each pin can be set on its own.

For every pin the block drives pad-control signals: an output level, a strong drive-high enable, a strong drive-low enable and a weak pull-up enable. The pad input level passes through a two-flop synchronizer. A data-register read returns that synchronized level. When the core flags the read as part of a read-modify-write, the read returns the latch value instead. The pin count and the latch reset value are parameters, so the same code serves an 8-pin port and a narrower 6-pin port.

The register interface is plain control: a write strobe, an address, write data and combinational read data. There is no handshake, and no back-pressure applies.

Top module: `gpio_port`

## Requirements
- R1: After reset both mode registers read 00h. The data latch holds the LATCH_RESET parameter (FFh for an 8-pin port, 0Fh for a 6-pin port).
- R2: Address 0 selects the data latch, address 1 selects mode register 0 and address 2 selects mode register 1. A write with `wr_en` high updates the addressed register on that clock edge, and mode reads return the stored values.
- R3: Each pin's mode is {mode1[n], mode0[n]}: 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain.
- R4: In push-pull mode, latch 1 enables only the strong drive-high, and latch 0 enables only the strong drive-low. The pull-up is off.
- R5: In open-drain mode, latch 0 enables only the strong drive-low. Latch 1 enables nothing.
- R6: In quasi-bidirectional mode, a steady latch 0 enables only the strong drive-low. A steady latch 1 enables only the weak pull-up.
- R7: In quasi-bidirectional mode, a 0-to-1 latch change enables strong drive-high for exactly the one cycle after the latch updates.
- R8: In input-only mode, the drive-high, drive-low and pull-up enables are all off, whatever the latch value.
- R9: A data read with `rmw_rd` low returns the pad input delayed through two flops, so a pad change is visible after the second clock edge. With `rmw_rd` high the read returns the latch.
- R10: Register bits at and above PINS read as zero and ignore writes. Address 3 reads zero.
- R11: Strong drive-high and strong drive-low are never enabled together on a pin.
- R12: `pad_out` always equals the pin's latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 data, 1 mode0, 2 mode1) |
| wr_data | input | 8 | Write data |
| rmw_rd | input | 1 | Data read returns latch instead of pad |
| rd_data | output | 8 | Combinational read data for `addr` |
| pad_in | input | PINS | Pad input levels (asynchronous) |
| pad_out | output | PINS | Output level per pin |
| drv_hi_en | output | PINS | Strong drive-high enable per pin |
| drv_lo_en | output | PINS | Strong drive-low enable per pin |
| pullup_en | output | PINS | Weak pull-up enable per pin |

## Verification
The assertions assume a single write per cycle, driven well clear of the clock edge. They also assume `pad_in` may change at any time, because the synchronizer absorbs it. The one-cycle check on the drive-high pulse relies on the latch not rising twice in consecutive cycles. That cannot happen, since a second rise needs a write of 0 in between. The bench drives every input on a clean offset after the edge. Its random loop writes mode0, mode1 and the latch in turn and then waits a cycle before comparing the drive outputs. It exercises the pulse in directed steps, where the cycle of interest is known.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_QUASI     = 2'b00,
    PM_PUSHPULL  = 2'b01,
    PM_INPUT     = 2'b10,
    PM_OPENDRAIN = 2'b11
  } pin_mode_e;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_MODE0 = 2'd1;
  localparam logic [1:0] ADDR_MODE1 = 2'd2;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 8,
  parameter logic [7:0] LATCH_RESET = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wr_data,
  output logic [PINS-1:0] latch_q,
  output logic [PINS-1:0] mode0_q,
  output logic [PINS-1:0] mode1_q
);
  localparam logic [PINS-1:0] LATCH_INIT = LATCH_RESET[PINS-1:0];

  logic [PINS-1:0] wr_bits;
  assign wr_bits = wr_data[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= LATCH_INIT;
      mode0_q <= '0;
      mode1_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_DATA:  latch_q <= wr_bits;
        ADDR_MODE0: mode0_q <= wr_bits;
        ADDR_MODE1: mode1_q <= wr_bits;
        default: ;
      endcase
    end
  end

  // R2
  mode0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_MODE0) |=> (mode0_q == $past(wr_data[PINS-1:0])));
  // R2
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_DATA) |=> (latch_q == $past(wr_data[PINS-1:0])));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= din;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
  import gpio_port_pkg::*;
#(
  parameter bit RST_LEVEL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      latch,
  output logic      pad_out,
  output logic      drv_hi,
  output logic      drv_lo,
  output logic      pull_up
);
  logic latch_prev_q;
  logic kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_prev_q <= RST_LEVEL;
    else        latch_prev_q <= latch;
  end

  assign kick    = latch & ~latch_prev_q;
  assign pad_out = latch;

  always_comb begin
    drv_hi  = 1'b0;
    drv_lo  = 1'b0;
    pull_up = 1'b0;
    unique case (mode)
      PM_QUASI: begin
        drv_lo  = ~latch;
        pull_up = latch;
        drv_hi  = kick;
      end
      PM_PUSHPULL: begin
        drv_hi = latch;
        drv_lo = ~latch;
      end
      PM_OPENDRAIN: drv_lo = ~latch;
      default: ;
    endcase
  end

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));
  // R8
  input_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_INPUT) |-> (!drv_hi && !drv_lo && !pull_up));
  // R5
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OPENDRAIN) |-> (!drv_hi && !pull_up));
  // R7
  kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_QUASI && drv_hi) |=> (mode != PM_QUASI || !drv_hi));
  // R7
  kick_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latch) && mode == PM_QUASI) |-> drv_hi);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 8,
  parameter logic [7:0] LATCH_RESET = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wr_data,
  input  logic            rmw_rd,
  output logic [7:0]      rd_data,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] drv_hi_en,
  output logic [PINS-1:0] drv_lo_en,
  output logic [PINS-1:0] pullup_en
);
  logic [PINS-1:0] latch_q, mode0_q, mode1_q, pad_sync;
  logic [PINS-1:0] rd_sel;

  gpio_port_regs #(.PINS(PINS), .LATCH_RESET(LATCH_RESET)) u_regs (
    .clk, .rst_n, .wr_en, .addr, .wr_data,
    .latch_q, .mode0_q, .mode1_q
  );

  gpio_port_sync #(.WIDTH(PINS), .STAGES(2)) u_sync (
    .clk, .rst_n, .din(pad_in), .dout(pad_sync)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_port_pin #(.RST_LEVEL(LATCH_RESET[i])) u_pin (
      .clk, .rst_n,
      .mode    (pin_mode_e'({mode1_q[i], mode0_q[i]})),
      .latch   (latch_q[i]),
      .pad_out (pad_out[i]),
      .drv_hi  (drv_hi_en[i]),
      .drv_lo  (drv_lo_en[i]),
      .pull_up (pullup_en[i])
    );
  end

  always_comb begin
    case (addr)
      ADDR_DATA:  rd_sel = rmw_rd ? latch_q : pad_sync;
      ADDR_MODE0: rd_sel = mode0_q;
      ADDR_MODE1: rd_sel = mode1_q;
      default:    rd_sel = '0;
    endcase
    rd_data = '0;
    rd_data[PINS-1:0] = rd_sel;
  end

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> PINS) == 8'd0);
  // R12
  pad_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_DATA) |=> (pad_out == $past(wr_data[PINS-1:0])));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rmw_rd = 1'b0;
  logic [7:0] pad_in = 8'd0;
  logic [7:0] rd_data, pad_out, hi, lo, pu;
  logic [7:0] rd6;
  logic [5:0] out6, hi6, lo6, pu6;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_latch, m_m0, m_m1;

  always #10ns clk = ~clk;

  gpio_port i_gpio_port (
    .clk, .rst_n, .wr_en, .addr, .wr_data, .rmw_rd, .rd_data,
    .pad_in, .pad_out, .drv_hi_en(hi), .drv_lo_en(lo), .pullup_en(pu)
  );

  gpio_port #(.PINS(6), .LATCH_RESET(8'h0F)) i_gpio_port6 (
    .clk, .rst_n, .wr_en, .addr, .wr_data, .rmw_rd, .rd_data(rd6),
    .pad_in(pad_in[5:0]), .pad_out(out6), .drv_hi_en(hi6), .drv_lo_en(lo6),
    .pullup_en(pu6)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (a)
      2'd0: m_latch = d;
      2'd1: m_m0 = d;
      2'd2: m_m1 = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] a, logic rmw, output logic [7:0] v);
    addr = a; rmw_rd = rmw; #1;
    v = rd_data;
  endtask

  // expected {hi,lo,pu} for steady state (no pulse)
  function automatic logic [23:0] exp_drv(logic [7:0] l, logic [7:0] m0, logic [7:0] m1);
    logic [7:0] eh, el, ep;
    eh = '0; el = '0; ep = '0;
    for (int i = 0; i < 8; i++) begin
      case ({m1[i], m0[i]})
        2'b00: begin el[i] = ~l[i]; ep[i] = l[i]; end
        2'b01: begin eh[i] = l[i]; el[i] = ~l[i]; end
        2'b11: el[i] = ~l[i];
        default: ;
      endcase
    end
    return {eh, el, ep};
  endfunction

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [23:0] e;
    void'($urandom(32'd1234));
    m_latch = 8'hFF; m_m0 = 8'h00; m_m1 = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(2'd0, 1'b1, v); chk("R1 latch", v, 8'hFF);
    chk("R1 latch6", rd6, 8'h0F);
    rd(2'd1, 1'b0, v); chk("R1 mode0", v, 8'h00);
    rd(2'd2, 1'b0, v); chk("R1 mode1", v, 8'h00);
    chk("R6 reset pullup", pu, 8'hFF);
    chk("R6 reset hi/lo", {hi, lo}, 16'h0000);

    // R10 narrow port
    wr(2'd1, 8'hFF);
    rd(2'd1, 1'b0, v); chk("R10 mode0 6-pin", rd6, 8'h3F);
    rd(2'd3, 1'b0, v); chk("R10 addr3", v, 8'h00);
    wr(2'd1, 8'h00);

    // R7 quasi pulse: drop pin 0 then raise it
    wr(2'd0, 8'hFE);
    chk("R6 quasi low", {hi[0], lo[0], pu[0]}, 3'b010);
    wr(2'd0, 8'hFF);
    chk("R7 pulse on", hi[0], 1'b1);
    chk("R11 pulse no low", lo[0], 1'b0);
    @(posedge clk); #1;
    chk("R7 pulse off", hi[0], 1'b0);
    chk("R6 quasi high", pu[0], 1'b1);

    // R3/R4 push-pull pin1, R5 open-drain pin2, R8 input-only pin3
    wr(2'd1, 8'h06); wr(2'd2, 8'h0C);
    wr(2'd0, 8'hF1);
    @(posedge clk); #1;
    chk("R4 pp low", {hi[1], lo[1], pu[1]}, 3'b010);
    chk("R5 od low", {hi[2], lo[2], pu[2]}, 3'b010);
    chk("R8 in idle", {hi[3], lo[3], pu[3]}, 3'b000);
    wr(2'd0, 8'hFF);
    chk("R4 pp high", {hi[1], lo[1], pu[1]}, 3'b100);
    chk("R5 od float", {hi[2], lo[2], pu[2]}, 3'b000);
    chk("R8 in idle high", {hi[3], lo[3], pu[3]}, 3'b000);
    chk("R12 pad_out", pad_out, 8'hFF);

    // R9 synchronizer latency
    pad_in = 8'hA5;
    @(posedge clk); #1;
    rd(2'd0, 1'b0, v); chk("R9 one edge old", v, 8'h00);
    @(posedge clk); #1;
    rd(2'd0, 1'b0, v); chk("R9 two edges", v, 8'hA5);
    rd(2'd0, 1'b1, v); chk("R9 rmw latch", v, 8'hFF);

    // random mix
    for (int it = 0; it < 200; it++) begin
      pad_in = 8'($urandom);
      wr(2'd1, 8'($urandom));
      wr(2'd2, 8'($urandom));
      wr(2'd0, 8'($urandom));
      @(posedge clk); #1;
      e = exp_drv(m_latch, m_m0, m_m1);
      chk("R3 drive", {hi, lo, pu}, e);
      chk("R11 contention", hi & lo, 8'h00);
      chk("R12 pad_out", pad_out, m_latch);
      rd(2'd1, 1'b0, v); chk("R2 mode0", v, m_m0);
      rd(2'd2, 1'b0, v); chk("R2 mode1", v, m_m1);
      rd(2'd0, 1'b1, v); chk("R2 latch", v, m_latch);
      rd(2'd0, 1'b0, v); chk("R9 pad", v, pad_in);
      chk("R10 6-pin data", rd6 & 8'hC0, 8'h00);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule